// File: doc/BRIEF.md
# GPIO Port Input Debounce Filter

This block cleans up the inputs of one general-purpose I/O port before they reach the interrupt and read logic. Every pin first passes through a multi-flop synchronizer. A filtered pin then changes its output only after its synchronized input has held a new level for a programmed number of millisecond ticks. The ticks come from an external prescaler on a one-cycle strobe input.

Configuration is deliberately split. A single stability count is shared by every pin of the port, and each pin has its own enable bit. The enable bits are updated through a masked write: one half of the write word selects which pins to touch, and the other half carries their new values. A pin whose enable is clear, or any pin while the shared count is zero, bypasses the filter and shows its synchronized input directly.

Top module: `gpio_port_debounce`

## Requirements
- R1: While `rst_n` is low, `pin_filt` is all zeros, the shared count is 0 and all enables are clear, so every pin is in bypass once reset is released.
- R2: Each raw input passes through `SYNC_STAGES` flops (default 2), so a bypassed pin shows a `pin_raw` change exactly 2 clock edges after it is applied.
- R3: A cycle with `cnt_wr` high loads `cnt_wdata` into the shared count; the full range up to 255 ticks is usable.
- R4: A cycle with `en_wr` high updates enable bit i only where `en_wdata[PINS+i]` (mask half, upper byte) is 1, taking the value `en_wdata[i]` (lower byte); bits whose mask is 0 keep their value.
- R5: A pin whose enable bit is 0 passes its synchronized input straight to `pin_filt`.
- R6: A shared count of 0 puts every pin in bypass, even pins whose enable bit is 1.
- R7: A filtered pin with count N takes its new level on the Nth tick edge during which its synchronized input differs from its output. With a tick on every cycle, this is edge 2+N after the raw change.
- R8: If the synchronized input returns to the output level before N ticks, the pin's stability counter restarts from zero.
- R9: Without `ms_tick`, a filtered pin never changes level, however long its input differs.
- R10: A new count value applies to all filtered pins at once, and each pin keeps its own counter.
- R11: Moving a pin from bypass to filtered causes no output change when its input is stable.
- R12: Rising and falling changes are filtered the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| cnt_wr | input | 1 | Load the shared stability count |
| cnt_wdata | input | CNT_W | New stability count in ticks |
| en_wr | input | 1 | Masked update of the per-pin enables |
| en_wdata | input | 2*PINS | Upper half: per-pin mask; lower half: enable values |
| pin_raw | input | PINS | Asynchronous pin inputs |
| pin_filt | output | PINS | Debounced or bypassed pin levels |

## Verification
The bench builds the block with its defaults: 8 pins, an 8-bit count and a 2-flop synchronizer. Because it drives `ms_tick` itself, often on every cycle, even the 255-tick maximum is reached in a few hundred cycles, and the boundary edge between "not yet" and "flipped" can be checked exactly. With eight pins, four pins can be filtered and four bypassed in the same vector, so the masked-enable and shared-count behaviour are seen side by side.

// File: rtl/gpdb_pkg.sv
`timescale 1ns/1ps
package gpdb_pkg;
  localparam int unsigned DEF_PINS        = 8;
  localparam int unsigned DEF_CNT_W       = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // Decision taken for one pin in a given cycle.
  typedef enum logic [1:0] {
    PH_BYPASS   = 2'd0,
    PH_STABLE   = 2'd1,
    PH_COUNTING = 2'd2
  } pin_phase_e;
endpackage

// File: rtl/gpdb_sync.sv
`timescale 1ns/1ps
module gpdb_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[k] <= '0;
        else        stage_q[k] <= stage_q[k-1];
      end

      // R2: every stage carries its predecessor one edge later
      p_stage_shift_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        stage_q[k] == $past(stage_q[k-1]));
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpdb_cfg.sv
`timescale 1ns/1ps
module gpdb_cfg #(
  parameter int unsigned PINS  = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              en_wr,
  input  logic [2*PINS-1:0] en_wdata,
  output logic [CNT_W-1:0]  count_o,
  output logic [PINS-1:0]   en_o,
  output logic [PINS-1:0]   active_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic [PINS-1:0]  en_q, en_d;
  logic [PINS-1:0]  wr_mask, wr_val;
  logic             count_live;

  assign wr_mask = en_wdata[2*PINS-1:PINS];
  assign wr_val  = en_wdata[PINS-1:0];

  // Next-state logic
  always_comb begin
    count_d = cnt_wdata;
    en_d    = (en_q & ~wr_mask) | (wr_val & wr_mask);
  end

  // Registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_wr) count_q <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_d;
  end

  assign count_live = |count_q;

  for (genvar i = 0; i < PINS; i++) begin : g_act
    assign active_o[i] = en_q[i] & count_live;

    // R4: unmasked enable bits survive a masked write
    p_mask_keep_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr && !wr_mask[i]) |=> (en_q[i] == $past(en_q[i])));
    // R4: masked enable bits take the written value
    p_mask_set_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr && wr_mask[i]) |=> (en_q[i] == $past(wr_val[i])));
  end

  assign count_o = count_q;
  assign en_o    = en_q;

  // R3: a count write is visible on the following cycle
  p_count_load_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count_q == $past(cnt_wdata)));
  // R3: without a write the count holds
  p_count_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> $stable(count_q));
endmodule

// File: rtl/gpdb_pin_filter.sv
`timescale 1ns/1ps
module gpdb_pin_filter
  import gpdb_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             filt_o
);
  localparam int unsigned RUN_W = CNT_W + 1;

  logic             level_q, level_d;
  logic [CNT_W-1:0] run_q, run_d;
  logic [RUN_W-1:0] run_inc;
  logic             reach;
  pin_phase_e       phase;

  assign run_inc = {1'b0, run_q} + RUN_W'(1);
  assign reach   = (run_inc >= {1'b0, count_i});

  // Next-state logic
  always_comb begin
    level_d = level_q;
    run_d   = run_q;
    if (!active_i)                phase = PH_BYPASS;
    else if (sync_i == level_q)   phase = PH_STABLE;
    else                          phase = PH_COUNTING;

    unique case (phase)
      PH_BYPASS: begin
        level_d = sync_i;
        run_d   = '0;
      end
      PH_STABLE: begin
        run_d = '0;
      end
      PH_COUNTING: begin
        if (tick_i) begin
          if (reach) begin
            level_d = sync_i;
            run_d   = '0;
          end else begin
            run_d = run_inc[CNT_W-1:0];
          end
        end
      end
      default: begin
        level_d = sync_i;
        run_d   = '0;
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      run_q   <= '0;
    end else begin
      level_q <= level_d;
      run_q   <= run_d;
    end
  end

  assign filt_o = active_i ? level_q : sync_i;

  // R9: a filtered level change needs a tick in the deciding cycle
  p_flip_needs_tick_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active_i) && (level_q != $past(level_q))) |-> $past(tick_i));
  // R7: a filtered level change adopts the synchronized input
  p_flip_takes_input_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active_i) && (level_q != $past(level_q))) |-> (level_q == $past(sync_i)));
  // R8: agreement between input and output restarts the counter
  p_match_clears_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && (sync_i == level_q)) |=> (run_q == '0));
endmodule

// File: rtl/gpio_port_debounce.sv
`timescale 1ns/1ps
module gpio_port_debounce
  import gpdb_pkg::*;
#(
  parameter int unsigned PINS        = DEF_PINS,
  parameter int unsigned CNT_W       = DEF_CNT_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              en_wr,
  input  logic [2*PINS-1:0] en_wdata,
  input  logic [PINS-1:0]   pin_raw,
  output logic [PINS-1:0]   pin_filt
);
  localparam int unsigned EN_W = 2 * PINS;

  logic [PINS-1:0]  pin_sync;
  logic [CNT_W-1:0] count;
  logic [PINS-1:0]  en_bits;
  logic [PINS-1:0]  active;
  logic [EN_W-1:0]  en_word;

  assign en_word = en_wdata;

  gpdb_sync #(
    .WIDTH  (PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_raw),
    .q_o   (pin_sync)
  );

  gpdb_cfg #(
    .PINS  (PINS),
    .CNT_W (CNT_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .en_wr     (en_wr),
    .en_wdata  (en_word),
    .count_o   (count),
    .en_o      (en_bits),
    .active_o  (active)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    gpdb_pin_filter #(
      .CNT_W (CNT_W)
    ) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (ms_tick),
      .active_i (active[i]),
      .sync_i   (pin_sync[i]),
      .count_i  (count),
      .filt_o   (pin_filt[i])
    );

    // R5 / R6: a disabled pin or a zero count leaves the pin unfiltered
    p_bypass_passes_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!en_bits[i] || (count == '0)) |-> (pin_filt[i] == pin_sync[i]));
  end

  // R1: outputs are cleared while reset is held
  always_comb begin
    if (!rst_n) a_reset_clear_r1 : assert (pin_filt == '0);
  end
endmodule

// File: tb/tb_gpio_port_debounce.sv
`timescale 1ns/1ps
module tb_gpio_port_debounce;
  localparam int unsigned PINS  = 8;
  localparam int unsigned CNT_W = 8;

  logic              clk;
  logic              rst_n;
  logic              ms_tick;
  logic              cnt_wr;
  logic [CNT_W-1:0]  cnt_wdata;
  logic              en_wr;
  logic [2*PINS-1:0] en_wdata;
  logic [PINS-1:0]   pin_raw;
  logic [PINS-1:0]   pin_filt;

  int n_checks = 0;
  int n_fail   = 0;

  gpio_port_debounce #(
    .PINS        (PINS),
    .CNT_W       (CNT_W),
    .SYNC_STAGES (2)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .pin_raw   (pin_raw),
    .pin_filt  (pin_filt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Vector: {raw[24:17], hold edges[16:9], tick[8], expected[7:0]}
  // Setup: count 3, pins 0-3 filtered, pins 4-7 bypassed; tick is R9 stimulus.
  localparam logic [24:0] VEC [10] = '{
    {8'hFF, 8'd8, 1'b1, 8'hFF},  // R12 rising, all pins settle
    {8'h00, 8'd2, 1'b1, 8'h0F},  // R5 bypass follows, R7 filtered holds
    {8'hFF, 8'd8, 1'b1, 8'hFF},  // R8 short glitch leaves no trace
    {8'h5A, 8'd8, 1'b0, 8'h5F},  // R9 no tick, filtered pins frozen
    {8'h5A, 8'd8, 1'b1, 8'h5A},  // R9 ticks resume, R12 falling
    {8'hA5, 8'd2, 1'b1, 8'hAA},  // R5 bypass half moves alone
    {8'h5A, 8'd8, 1'b1, 8'h5A},  // R8 glitch discarded
    {8'h33, 8'd8, 1'b1, 8'h33},  // R7 mixed pattern
    {8'hCC, 8'd8, 1'b1, 8'hCC},  // R12 both directions at once
    {8'h00, 8'd8, 1'b1, 8'h00}   // R7 back to idle
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [PINS-1:0] act,
                     input logic [PINS-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_count(input logic [CNT_W-1:0] v);
    cnt_wr    = 1'b1;
    cnt_wdata = v;
    step(1);
    cnt_wr    = 1'b0;
  endtask

  task automatic write_en(input logic [PINS-1:0] mask, input logic [PINS-1:0] val);
    en_wr    = 1'b1;
    en_wdata = {mask, val};
    step(1);
    en_wr    = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #600000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    ms_tick   = 1'b0;
    cnt_wr    = 1'b0;
    cnt_wdata = '0;
    en_wr     = 1'b0;
    en_wdata  = '0;
    pin_raw   = 8'h3C;
    step(3);
    chk("R1 outputs cleared in reset", pin_filt, 8'h00);
    rst_n = 1'b1;
    step(2);
    chk("R1 bypass after reset", pin_filt, 8'h3C);

    // R2 synchronizer latency
    pin_raw = 8'hC3;
    step(1);
    chk("R2 one edge, old value", pin_filt, 8'h3C);
    step(1);
    chk("R2 two edges, new value", pin_filt, 8'hC3);

    // Table setup
    pin_raw = 8'h00;
    step(3);
    write_count(8'd3);
    write_en(8'hFF, 8'h0F);
    step(1);
    chk("R3 settled before table", pin_filt, 8'h00);

    for (int i = 0; i < 10; i++) begin
      pin_raw = VEC[i][24:17];
      ms_tick = VEC[i][8];
      step(int'(VEC[i][16:9]));
      chk($sformatf("R7 table vector %0d", i), pin_filt, VEC[i][7:0]);
    end
    ms_tick = 1'b1;

    // R6: zero count bypasses enabled pins
    write_count(8'd0);
    pin_raw = 8'hFF;
    step(2);
    chk("R6 zero count bypasses", pin_filt, 8'hFF);
    pin_raw = 8'h00;
    step(2);
    chk("R6 zero count bypasses falling", pin_filt, 8'h00);

    // R4: masked enable writes
    write_en(8'hFF, 8'h01);
    write_count(8'd3);
    pin_raw = 8'hFF;
    step(2);
    chk("R4 only pin0 filtered", pin_filt, 8'hFE);
    step(3);
    chk("R4 pin0 flips after count", pin_filt, 8'hFF);
    write_en(8'hFE, 8'hFE);
    pin_raw = 8'h00;
    step(2);
    chk("R4 unmasked pin0 kept its enable", pin_filt, 8'hFF);
    step(3);
    chk("R4 all pins flip together", pin_filt, 8'h00);

    // R11: bypass to filtered without a change
    write_en(8'hFF, 8'h00);
    pin_raw = 8'hAA;
    step(4);
    chk("R11 bypass before enable", pin_filt, 8'hAA);
    write_en(8'hFF, 8'hFF);
    chk("R11 no change at enable", pin_filt, 8'hAA);
    step(4);
    chk("R11 still stable", pin_filt, 8'hAA);

    // R10: new shared count applies to all pins
    write_count(8'd5);
    pin_raw = 8'h55;
    step(6);
    chk("R10 count 5 not yet", pin_filt, 8'hAA);
    step(1);
    chk("R10 count 5 reached", pin_filt, 8'h55);

    // R9: sparse ticks
    ms_tick = 1'b0;
    pin_raw = 8'hAA;
    step(20);
    chk("R9 no ticks, no change", pin_filt, 8'h55);
    for (int k = 0; k < 4; k++) begin
      ms_tick = 1'b1;
      step(1);
      ms_tick = 1'b0;
      step(3);
    end
    chk("R9 four ticks below count", pin_filt, 8'h55);
    ms_tick = 1'b1;
    step(1);
    ms_tick = 1'b0;
    chk("R9 fifth tick flips", pin_filt, 8'hAA);

    // R3: maximum count 255
    ms_tick = 1'b1;
    write_count(8'd255);
    pin_raw = 8'h55;
    step(256);
    chk("R3 count 255 one short", pin_filt, 8'hAA);
    step(1);
    chk("R3 count 255 reached", pin_filt, 8'h55);

    // R7: exact edge for count 3
    write_count(8'd3);
    pin_raw = 8'hAA;
    step(4);
    chk("R7 count 3 one short", pin_filt, 8'h55);
    step(1);
    chk("R7 count 3 exact edge", pin_filt, 8'hAA);

    // R8: glitch restarts the counter
    pin_raw = 8'h55;
    step(2);
    pin_raw = 8'hAA;
    step(1);
    pin_raw = 8'h55;
    step(4);
    chk("R8 restart delays flip", pin_filt, 8'hAA);
    step(1);
    chk("R8 flip after full count", pin_filt, 8'h55);

    finish_run();
  end
endmodule